// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter Chain

This block keeps wall-clock time and date as a chain of 4-bit BCD digit registers: seconds, minutes, hours (with a PM flag in 12-hour mode), day of month, month, two-digit year and a weekday count. A sub-second divider turns a 64 Hz tick into whole seconds. A direct one-second tick input can also advance the chain, for use with an external prescaler. Each advance ripples through the digits. Month lengths and February in leap years are handled without software help. The block raises one-cycle carry pulses on every second, minute and hour rollover for the interrupt logic.

Software reaches the block through a 4-bit address and 4-bit data bus. Thirteen addresses hold one digit each. Two further addresses hold control bits:
- hold, which freezes the visible time and remembers one pending second;
- stop, which freezes counting;
- divider clear;
- 12/24-hour selection;
- a one-shot 30-second round-off.

A busy flag marks the cycle in which an increment is applied.

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the time is 00:00:00 on day 01, month 01, year 00, weekday 0. The block is in 24-hour mode and the PM flag is 0. Hold, stop and divider clear are all 0, so address 15 reads 0100 and address 13 reads 0000.
- R2: Addresses 0 to 12 hold these digits in this order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day units, day tens, month units, month tens, year units, year tens, weekday. Each digit is written on its own and reads back at its own address. At address 5, bits 1:0 are the hours-tens digit and bit 2 is the PM flag (1 = PM). At address 13, bit 0 is hold (read/write), bit 1 is busy (read-only) and bit 2 is round-off (write-only, reads 0). At address 15, bit 0 is divider clear, bit 1 is stop and bit 2 is 24-hour mode (1 = 24-hour).
- R3: Seconds and minutes units count 0 to 9 and their tens count 0 to 5. `carry_sec` pulses on every applied second. `carry_min` pulses when the second wraps from 59. `carry_hour` pulses when minutes and seconds wrap from 59:59.
- R4: In 24-hour mode the hours count 00 to 23. The step from 23 to 00 advances the day.
- R5: In 12-hour mode the hours run 12, 1, 2 … 11. The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM advances the day.
- R6: April, June, September and November roll over after day 30. January, March, May, July, August, October and December roll over after day 31. The day restarts at 01.
- R7: February rolls over after day 29 when the two-digit year is divisible by 4, and after day 28 otherwise.
- R8: Month 12 rolls over to 01 and advances the year. Year 99 rolls over to 00. The weekday counts 0 to 6 and steps once per day rollover.
- R9: A whole second is applied after every 64 ticks of `frac_tick`. While divider clear is set, the divider is held at zero, which discards a partly counted second.
- R10: While stop is set, neither `sec_tick` nor `frac_tick` changes the time.
- R11: While hold is set, the time does not change. Any number of seconds that arrive during hold are applied as exactly one second once hold is released. `busy` is high in exactly the cycles in which a second is applied.
- R12: Writing 1 to the round-off bit clears the seconds. If the seconds were 30 to 59, the minute also advances, with full carry up the chain.
- R13: A second that arrives in a cycle with a bus write is not lost. It is applied in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frac_tick | input | 1 | 64 Hz tick, one clock wide |
| sec_tick | input | 1 | Direct one-second tick, one clock wide |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for `addr` (combinational) |
| busy | output | 1 | High while a second is being applied |
| carry_sec | output | 1 | Pulse on each applied second |
| carry_min | output | 1 | Pulse on minute carry |
| carry_hour | output | 1 | Pulse on hour carry |

## Verification
The bench pushes random dates to the edges of each field: 59 seconds, 59 minutes, hours 11 and 23 in both modes, and the last day of every month over many years. An independent integer-time model checks every digit after each tick. A chain that compared against a fixed 31, or that tested the year for leap with the wrong BCD rule, would land on a wrong day in these runs. So would a 12-hour chain that toggled PM at 12 to 1.

Directed cases cover the remaining corner cases:
- Round-off on each side of 30 seconds. A comparison off by one would round the wrong way or drop the minute carry.
- Two ticks during hold. They must produce exactly one second, not zero and not two.
- A tick that collides with a bus write. The tick must survive the write.
- A partial 64 Hz count discarded by divider clear. A design that ignored the clear would advance early.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [3:0] s1;
    logic [2:0] s10;
    logic [3:0] m1;
    logic [2:0] m10;
    logic [3:0] h1;
    logic [1:0] h10;
    logic       pm;
    logic [3:0] d1;
    logic [1:0] d10;
    logic [3:0] mo1;
    logic       mo10;
    logic [3:0] y1;
    logic [3:0] y10;
    logic [2:0] wk;
  } cal_t;

  typedef struct packed {
    cal_t t;
    logic c_min;
    logic c_hr;
    logic c_day;
  } step_t;

  localparam cal_t CAL_RESET = '{s1: 4'd0, s10: 3'd0, m1: 4'd0, m10: 3'd0,
                                 h1: 4'd0, h10: 2'd0, pm: 1'b0, d1: 4'd1,
                                 d10: 2'd0, mo1: 4'd1, mo10: 1'b0, y1: 4'd0,
                                 y10: 4'd0, wk: 3'd0};

  // Divisible by 4 in BCD: an even tens digit needs units 0/4/8, an odd one 2/6.
  function automatic logic leap_yr(input logic [3:0] y10, input logic [3:0] y1);
    return y10[0] ? (y1 == 4'd2 || y1 == 4'd6)
                  : (y1 == 4'd0 || y1 == 4'd4 || y1 == 4'd8);
  endfunction

  // Last day of the month as packed BCD {tens[1:0], units[3:0]}.
  function automatic logic [5:0] last_day(input logic mo10, input logic [3:0] mo1,
                                          input logic [3:0] y10, input logic [3:0] y1);
    if (!mo10 && mo1 == 4'd2)
      return leap_yr(y10, y1) ? 6'h29 : 6'h28;
    else if ((!mo10 && (mo1 == 4'd4 || mo1 == 4'd6 || mo1 == 4'd9)) ||
             (mo10 && mo1 == 4'd1))
      return 6'h30;
    else
      return 6'h31;
  endfunction

  // One step of the chain. With from_min set the step enters at the minutes digits.
  function automatic step_t advance(input cal_t c, input logic mode24, input logic from_min);
    step_t r;
    r.t     = c;
    r.c_min = from_min;
    r.c_hr  = 1'b0;
    r.c_day = 1'b0;
    if (!from_min) begin
      if (c.s1 == 4'd9) begin
        r.t.s1 = 4'd0;
        if (c.s10 == 3'd5) begin r.t.s10 = 3'd0; r.c_min = 1'b1; end
        else r.t.s10 = c.s10 + 3'd1;
      end else r.t.s1 = c.s1 + 4'd1;
    end
    if (r.c_min) begin
      if (c.m1 == 4'd9) begin
        r.t.m1 = 4'd0;
        if (c.m10 == 3'd5) begin r.t.m10 = 3'd0; r.c_hr = 1'b1; end
        else r.t.m10 = c.m10 + 3'd1;
      end else r.t.m1 = c.m1 + 4'd1;
    end
    if (r.c_hr) begin
      if (mode24 && c.h10 == 2'd2 && c.h1 == 4'd3) begin
        r.t.h10 = 2'd0; r.t.h1 = 4'd0; r.c_day = 1'b1;
      end else if (!mode24 && c.h10 == 2'd1 && c.h1 == 4'd1) begin
        r.t.h1 = 4'd2; r.t.pm = ~c.pm; r.c_day = c.pm;
      end else if (!mode24 && c.h10 == 2'd1 && c.h1 == 4'd2) begin
        r.t.h10 = 2'd0; r.t.h1 = 4'd1;
      end else if (c.h1 == 4'd9) begin
        r.t.h1 = 4'd0; r.t.h10 = c.h10 + 2'd1;
      end else r.t.h1 = c.h1 + 4'd1;
    end
    if (r.c_day) begin
      r.t.wk = (c.wk >= 3'd6) ? 3'd0 : c.wk + 3'd1;
      if ({c.d10, c.d1} == last_day(c.mo10, c.mo1, c.y10, c.y1)) begin
        r.t.d10 = 2'd0; r.t.d1 = 4'd1;
        if (c.mo10 && c.mo1 == 4'd2) begin
          r.t.mo10 = 1'b0; r.t.mo1 = 4'd1;
          if (c.y1 == 4'd9) begin
            r.t.y1  = 4'd0;
            r.t.y10 = (c.y10 == 4'd9) ? 4'd0 : c.y10 + 4'd1;
          end else r.t.y1 = c.y1 + 4'd1;
        end else if (c.mo1 == 4'd9) begin
          r.t.mo1 = 4'd0; r.t.mo10 = 1'b1;
        end else r.t.mo1 = c.mo1 + 4'd1;
      end else if (c.d1 == 4'd9) begin
        r.t.d1 = 4'd0; r.t.d10 = c.d10 + 2'd1;
      end else r.t.d1 = c.d1 + 4'd1;
    end
    return r;
  endfunction

  // Replace one digit, masked to the width of its register.
  function automatic cal_t write_digit(input cal_t c, input logic [3:0] sel, input logic [3:0] v);
    cal_t r;
    r = c;
    case (sel)
      4'd0:  r.s1  = v;
      4'd1:  r.s10 = v[2:0];
      4'd2:  r.m1  = v;
      4'd3:  r.m10 = v[2:0];
      4'd4:  r.h1  = v;
      4'd5:  begin r.h10 = v[1:0]; r.pm = v[2]; end
      4'd6:  r.d1  = v;
      4'd7:  r.d10 = v[1:0];
      4'd8:  r.mo1 = v;
      4'd9:  r.mo10 = v[0];
      4'd10: r.y1  = v;
      4'd11: r.y10 = v;
      4'd12: r.wk  = v[2:0];
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_sub_divider.sv
module cal_sub_divider #(
  parameter int TICKS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frac_tick,
  input  logic                       clear,
  input  logic                       freeze,
  output logic [$clog2(TICKS)-1:0]   count,
  output logic                       wrap
);
  localparam int CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  assign wrap = frac_tick && !freeze && !clear && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clear)              count <= '0;
    else if (frac_tick && !freeze) count <= wrap ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/cal_sec_gate.sv
module cal_sec_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_evt,
  input  logic hold,
  input  logic stop,
  input  logic blocked,
  output logic adv,
  output logic pend
);
  logic evt_live;

  assign evt_live = sec_evt && !stop;
  assign adv      = !hold && !stop && !blocked && (evt_live || pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend || evt_live) && !adv;
  end
endmodule

// File: rtl/cal_digit_chain.sv
module cal_digit_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       adj,
  input  logic       mode24,
  input  logic       dig_we,
  input  logic [3:0] dig_sel,
  input  logic [3:0] dig_val,
  output cal_t       now,
  output logic       carry_min,
  output logic       carry_hour
);
  step_t sec_step, adj_step;
  cal_t  zeroed;
  logic  round_up;

  always_comb begin
    sec_step   = advance(now, mode24, 1'b0);
    zeroed     = now;
    zeroed.s1  = 4'd0;
    zeroed.s10 = 3'd0;
    round_up   = (now.s10 >= 3'd3);
    adj_step   = advance(zeroed, mode24, 1'b1);
  end

  assign carry_min  = (adv && sec_step.c_min) || (adj && round_up);
  assign carry_hour = (adv && sec_step.c_hr) || (adj && round_up && adj_step.c_hr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      now <= CAL_RESET;
    else if (dig_we) now <= write_digit(now, dig_sel, dig_val);
    else if (adj)    now <= round_up ? adj_step.t : zeroed;
    else if (adv)    now <= sec_step.t;
  end
endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frac_tick,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  output logic [3:0] rdata,
  output logic       busy,
  output logic       carry_sec,
  output logic       carry_min,
  output logic       carry_hour
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [3:0] LAST_DIGIT = 4'd12;
  localparam logic [3:0] CTRL_A     = 4'd13;
  localparam logic [3:0] CTRL_B     = 4'd15;

  logic          hold_q, stop_q, rest_q, mode24_q;
  logic [CW-1:0] sub_count;
  logic          div_wrap, adv, pend, adj, dig_we;
  cal_t          cal_now;

  assign dig_we = wr_en && (addr <= LAST_DIGIT);
  assign adj    = wr_en && (addr == CTRL_A) && wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0; stop_q <= 1'b0; rest_q <= 1'b0; mode24_q <= 1'b1;
    end else if (wr_en && addr == CTRL_A) begin
      hold_q <= wdata[0];
    end else if (wr_en && addr == CTRL_B) begin
      rest_q <= wdata[0]; stop_q <= wdata[1]; mode24_q <= wdata[2];
    end
  end

  cal_sub_divider #(.TICKS(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .frac_tick(frac_tick), .clear(rest_q),
    .freeze(stop_q), .count(sub_count), .wrap(div_wrap)
  );

  cal_sec_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sec_evt(div_wrap || sec_tick), .hold(hold_q),
    .stop(stop_q), .blocked(wr_en), .adv(adv), .pend(pend)
  );

  cal_digit_chain u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .adj(adj), .mode24(mode24_q),
    .dig_we(dig_we), .dig_sel(addr), .dig_val(wdata), .now(cal_now),
    .carry_min(carry_min), .carry_hour(carry_hour)
  );

  assign busy      = adv;
  assign carry_sec = adv;

  always_comb begin
    case (addr)
      4'd0:  rdata = cal_now.s1;
      4'd1:  rdata = {1'b0, cal_now.s10};
      4'd2:  rdata = cal_now.m1;
      4'd3:  rdata = {1'b0, cal_now.m10};
      4'd4:  rdata = cal_now.h1;
      4'd5:  rdata = {1'b0, cal_now.pm, cal_now.h10};
      4'd6:  rdata = cal_now.d1;
      4'd7:  rdata = {2'b0, cal_now.d10};
      4'd8:  rdata = cal_now.mo1;
      4'd9:  rdata = {3'b0, cal_now.mo10};
      4'd10: rdata = cal_now.y1;
      4'd11: rdata = cal_now.y10;
      4'd12: rdata = {1'b0, cal_now.wk};
      4'd13: rdata = {2'b0, busy, hold_q};
      4'd15: rdata = {1'b0, mode24_q, stop_q, rest_q};
      default: rdata = 4'd0;
    endcase
  end
endmodule

// File: rtl/cal_chain_chk.sv
module cal_chain_chk #(
  parameter int CW = 6,
  parameter int VW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          hold,
  input logic          stop,
  input logic          rest,
  input logic          busy,
  input logic          carry_min,
  input logic          carry_hour,
  input logic [3:0]    s1,
  input logic [2:0]    s10,
  input logic [VW-1:0] cal_vec,
  input logic [CW-1:0] sub_count
);
  // R3
  min_carry_zeroes_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_min |=> (s1 == 4'd0 && s10 == 3'd0));
  // R3
  hour_needs_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_hour |-> carry_min);
  // R11
  hold_freezes_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(cal_vec));
  // R11
  busy_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$stable(s1));
  // R10
  stop_blocks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !busy);
  // R9
  rest_clears_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest |=> (sub_count == '0));
endmodule

bind bcd_calendar_chain cal_chain_chk #(.CW(CW), .VW($bits(cal_pkg::cal_t))) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hold(hold_q), .stop(stop_q),
  .rest(rest_q), .busy(busy), .carry_min(carry_min), .carry_hour(carry_hour),
  .s1(cal_now.s1), .s10(cal_now.s10), .cal_vec(cal_now), .sub_count(sub_count)
);

// File: tb/bcd_calendar_chain_tb.sv
`timescale 1ns/1ps
module bcd_calendar_chain_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frac_tick = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'd0, wdata = 4'd0, rdata;
  logic busy, carry_sec, carry_min, carry_hour;
  int checks = 0, errors = 0;
  bit done = 0;

  // model state: 24-hour internal hour
  int ms, mm, mh, md, mmo, my, mw;
  bit m24;

  always #2 clk = ~clk;

  bcd_calendar_chain u_dut (
    .clk(clk), .rst_n(rst_n), .frac_tick(frac_tick), .sec_tick(sec_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy),
    .carry_sec(carry_sec), .carry_min(carry_min), .carry_hour(carry_hour)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dim(input int mo, input int y);
    case (mo)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic int disp_hour();
    if (m24) return mh;
    return (mh % 12 == 0) ? 12 : mh % 12;
  endfunction

  function automatic int exp_nib(input int a);
    case (a)
      0: return ms % 10;   1: return ms / 10;
      2: return mm % 10;   3: return mm / 10;
      4: return disp_hour() % 10;
      5: return disp_hour() / 10 + ((!m24 && mh >= 12) ? 4 : 0);
      6: return md % 10;   7: return md / 10;
      8: return mmo % 10;  9: return mmo / 10;
      10: return my % 10;  11: return my / 10;
      default: return mw;
    endcase
  endfunction

  task automatic model_sec();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = 4'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 4'(a); #1; d = int'(rdata);
  endtask

  task automatic load_model();
    wr(15, m24 ? 4 : 0);
    for (int a = 0; a < 13; a++) wr(a, exp_nib(a));
  endtask

  task automatic compare_all(input string req);
    int v;
    for (int a = 0; a < 13; a++) begin
      rd(a, v);
      check($sformatf("%s digit %0d", req, a), v, exp_nib(a));
    end
  endtask

  // one applied second with its pulses checked (R3 carries, R11 busy)
  task automatic tick_sec();
    @(negedge clk); sec_tick = 1'b1; #1;
    check("R11 busy on advance", int'(busy), 1);
    check("R3 carry_sec", int'(carry_sec), 1);
    check("R3 carry_min", int'(carry_min), int'(ms == 59));
    check("R3 carry_hour", int'(carry_hour), int'(ms == 59 && mm == 59));
    @(negedge clk); sec_tick = 1'b0;
    model_sec();
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_time(input bit t24, input int y, input int mo, input int d,
                          input int h, input int mi, input int s, input int w);
    m24 = t24; my = y; mmo = mo; md = d; mh = h; mm = mi; ms = s; mw = w;
    load_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd20240229));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    m24 = 1; ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
    compare_all("R1 reset");
    rd(15, v); check("R1 ctrl B reset", v, 4);
    rd(13, v); check("R1 ctrl A reset", v, 0);

    // R2 PM bit readback at bit 2 of address 5
    set_time(0, 5, 6, 7, 15, 8, 9, 3);
    rd(5, v); check("R2 hours tens with PM", v, 4);
    compare_all("R2 digit map");

    // R4 24-hour day rollover
    set_time(1, 41, 7, 14, 23, 59, 59, 2);
    tick_sec(); compare_all("R4 23->00");

    // R5 12-hour sequence
    set_time(0, 10, 3, 3, 11, 59, 59, 1);  tick_sec(); compare_all("R5 11AM->12PM");
    set_time(0, 10, 3, 3, 23, 59, 59, 1);  tick_sec(); compare_all("R5 11PM->12AM");
    set_time(0, 10, 3, 3, 12, 59, 59, 1);  tick_sec(); compare_all("R5 12PM->1PM");

    // R6 / R7 / R8 directed month ends
    set_time(1, 23, 4, 30, 23, 59, 59, 0); tick_sec(); compare_all("R6 Apr 30");
    set_time(1, 23, 2, 28, 23, 59, 59, 0); tick_sec(); compare_all("R7 non-leap Feb");
    set_time(1, 24, 2, 28, 23, 59, 59, 0); tick_sec(); compare_all("R7 leap Feb 28");
    set_time(1, 0, 2, 29, 23, 59, 59, 0);  tick_sec(); compare_all("R7 year 00 Feb 29");
    set_time(1, 99, 12, 31, 23, 59, 59, 6); tick_sec(); compare_all("R8 year 99 wrap");

    // random sweep over field edges (R3..R8)
    for (int i = 0; i < 150; i++) begin
      int n;
      m24 = bit'($urandom % 2);
      my = $urandom % 100; mmo = 1 + $urandom % 12;
      md = ($urandom % 2) ? dim(mmo, my) : 1 + $urandom % dim(mmo, my);
      case ($urandom % 3) 0: mh = 23; 1: mh = 11; default: mh = $urandom % 24; endcase
      mm = ($urandom % 2) ? 59 : $urandom % 60;
      ms = 55 + $urandom % 5; mw = $urandom % 7;
      load_model();
      n = 1 + $urandom % 6;
      for (int k = 0; k < n; k++) tick_sec();
      compare_all("R6 R7 R8 random");
    end

    // R12 round-off
    set_time(1, 12, 5, 5, 10, 20, 29, 4); wr(13, 4); ms = 0; compare_all("R12 below 30");
    set_time(1, 12, 5, 5, 10, 20, 30, 4); wr(13, 4); ms = 59; model_sec(); compare_all("R12 at 30");
    set_time(1, 12, 5, 31, 23, 59, 45, 4); wr(13, 4); ms = 59; model_sec(); compare_all("R12 day carry");
    rd(13, v); check("R12 round bit reads 0", v, 0);

    // R10 stop
    set_time(1, 30, 8, 8, 8, 8, 8, 1);
    wr(15, 6);
    pulse_sec(); pulse_sec();
    @(negedge clk); frac_tick = 1'b1; repeat (70) @(negedge clk); frac_tick = 1'b0;
    compare_all("R10 stopped");
    wr(15, 4);

    // R9 divider: 64 fractional ticks make one second
    @(negedge clk); frac_tick = 1'b1; repeat (64) @(negedge clk); frac_tick = 1'b0;
    model_sec(); compare_all("R9 64 ticks");
    @(negedge clk); frac_tick = 1'b1; repeat (40) @(negedge clk); frac_tick = 1'b0;
    wr(15, 5); wr(15, 4);
    @(negedge clk); frac_tick = 1'b1; repeat (63) @(negedge clk); frac_tick = 1'b0;
    compare_all("R9 clear discards partial");
    @(negedge clk); frac_tick = 1'b1; @(negedge clk); frac_tick = 1'b0;
    model_sec(); compare_all("R9 after clear");

    // R11 hold with one remembered second
    wr(13, 1);
    rd(13, v); check("R11 hold bit", v, 1);
    pulse_sec(); pulse_sec();
    compare_all("R11 held");
    wr(13, 0);
    @(negedge clk); @(negedge clk);
    model_sec(); compare_all("R11 one pending applied");

    // R13 tick during a bus write
    @(negedge clk); sec_tick = 1'b1; wr_en = 1'b1; addr = 4'd12; wdata = 4'd5;
    @(negedge clk); sec_tick = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    mw = 5; model_sec(); compare_all("R13 deferred second");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule